// File: doc/BRIEF.md
# L1 Data Cache Maintenance Sequencer

This block runs software maintenance commands against a small direct-mapped, write-back data cache. The cache state is a tag, valid bit, dirty bit and line of data per entry. Software drives a register write port. A select code chooses between the control register and four commands: invalidate everything, flush everything, invalidate one line and flush one line. The per-line commands carry a physical address in the write data. The control register holds a cache-disable bit and an invalidate-mode bit. The same read word also reports a flush-in-progress flag.

Once a command is accepted, a walker visits the affected line indices one per cycle. When the command calls for write-back, every line that is both valid and dirty is pushed out as a whole-line write on a valid/ready memory write port. Its dirty bit is then cleared. The walker clears valid bits when the command invalidates. A plain invalidate discards dirty data. An invalidate issued with the mode bit set writes that data back before discarding it. A line install port stands in for the refill path so that the array can be given contents. It only takes effect while the walker is idle.

The line length in bytes is 16 shifted left by a line-length parameter. That length fixes the address alignment of lines and of write-backs.

Top module: `dcache_maint`

## Requirements
- R1: After reset, `aux_wr_ready` is 1, `ctrl_rdata` is 0 (cache enabled, discard-mode invalidate, not busy), and `mem_wr_valid` is 0.
- R2: A write with select 0 stores data bit 0 (disable) and data bit 6 (invalidate mode). `ctrl_rdata` returns them at bits 0 and 6, returns flush status at bit 8 and returns 0 in every other bit. Bit 8 of the write data has no effect. Writing 0 clears both bits in one access.
- R3: Select 2 (flush all) writes back every valid dirty line, in ascending index order, and leaves the lines valid with their dirty bits cleared. A second flush all therefore makes no memory writes.
- R4: With mode bit 6 clear, select 1 (invalidate all) and select 3 (invalidate line) discard lines with no memory write. A later flush all writes nothing for the discarded lines.
- R5: With mode bit 6 set, invalidate commands write back each valid dirty line before clearing its valid bit.
- R6: `ctrl_rdata` bit 8 reads 1 from the cycle after a flush, or an invalidate with mode bit 6 set, is accepted, until the walk ends. After the walk it reads 0. It stays 0 during a discard-mode invalidate.
- R7: `aux_wr_ready` is low while a command is being carried out. A register write presented then, including a control write, is held off and takes effect only after the walk completes.
- R8: Per-line commands (select 3 invalidate, select 4 flush) ignore the address bits below the line size and act on the line containing the address. The index comes from the bits just above the offset and the tag from the bits above those.
- R9: A per-line command whose address tag does not match a valid line changes no cache state and makes no memory write.
- R10: A per-line flush writes back only the addressed line, leaving other dirty lines dirty.
- R11: While disable bit 0 is set, commands are accepted without a stall and change no cache state.
- R12: Lines that are valid but clean, or invalid, never produce a memory write.
- R13: Every write-back address has its low log2(line bytes) bits at zero and equals tag, index and zero offset of the line. Its data is the whole stored line.
- R14: While `mem_wr_valid` is high and `mem_wr_ready` is low, the write request stays asserted with stable address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_wr_valid | input | 1 | Register write request |
| aux_wr_ready | output | 1 | Register write accepted when high with valid |
| aux_wr_sel | input | 3 | 0 control, 1 invalidate all, 2 flush all, 3 invalidate line, 4 flush line |
| aux_wr_data | input | ADDR_W | Control value or physical address |
| ctrl_rdata | output | ADDR_W | Control read: bit 0 disable, bit 6 invalidate mode, bit 8 flush busy |
| fill_en | input | 1 | Install a line (ignored while walking) |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_data | input | DATA_W | Line contents |
| fill_dirty | input | 1 | Installed line is dirty |
| mem_wr_valid | output | 1 | Write-back request |
| mem_wr_ready | input | 1 | Memory accepts write-back |
| mem_wr_addr | output | ADDR_W | Line-aligned write-back address |
| mem_wr_data | output | DATA_W | Write-back line data |

## Verification
The bench mixes clean and dirty lines across all indices with memory backpressure. A design that skipped a dirty line, wrote a clean one or reordered the walk would leave the scoreboard with a missing or unexpected write. Discard versus write-back invalidate is exercised in both mode settings. A per-line command is given an offset address, another given a mismatching tag, and both must hit only the right line: an implementation that compared the full address, or ignored the tag, would write nothing or the wrong line. A control write issued mid-walk must stall until the walk ends, and commands issued while disabled must leave contents intact for a later flush.

// File: rtl/dcache_maint_pkg.sv
package dcache_maint_pkg;

   typedef enum logic [2:0] {
      SEL_CTRL       = 3'd0,
      SEL_INV_ALL    = 3'd1,
      SEL_FLUSH_ALL  = 3'd2,
      SEL_INV_LINE   = 3'd3,
      SEL_FLUSH_LINE = 3'd4
   } aux_sel_e;

   localparam int CTRL_DIS_BIT   = 0;
   localparam int CTRL_IMODE_BIT = 6;
   localparam int CTRL_BUSY_BIT  = 8;

endpackage

// File: rtl/dcache_maint_store.sv
module dcache_maint_store #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3,
   parameter int TAG_W     = 25,
   parameter int DATA_W    = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              fill_dirty,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              clr_en,
   input  logic              clr_valid,
   input  logic              clr_dirty
);

   logic [NUM_LINES-1:0] valid_vec;
   logic [NUM_LINES-1:0] dirty_vec;
   logic [TAG_W-1:0]     tag_arr  [NUM_LINES];
   logic [DATA_W-1:0]    data_arr [NUM_LINES];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic              v_q, d_q;
      logic [TAG_W-1:0]  t_q;
      logic [DATA_W-1:0] l_q;
      logic              fill_me, clr_me;

      assign fill_me = fill_en && (fill_idx == IDX_W'(i));
      assign clr_me  = clr_en && (rd_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
         end else if (fill_me) begin
            v_q <= 1'b1;
            d_q <= fill_dirty;
         end else if (clr_me) begin
            if (clr_valid) v_q <= 1'b0;
            if (clr_dirty) d_q <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_me) begin
            t_q <= fill_tag;
            l_q <= fill_data;
         end
      end

      assign valid_vec[i] = v_q;
      assign dirty_vec[i] = d_q;
      assign tag_arr[i]   = t_q;
      assign data_arr[i]  = l_q;
   end

   assign rd_valid = valid_vec[rd_idx];
   assign rd_dirty = dirty_vec[rd_idx];
   assign rd_tag   = tag_arr[rd_idx];
   assign rd_data  = data_arr[rd_idx];

endmodule

// File: rtl/dcache_maint_walker.sv
module dcache_maint_walker #(
   parameter int ADDR_W    = 32,
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3,
   parameter int OFF_W     = 4,
   parameter int TAG_W     = 25,
   parameter int DATA_W    = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_all,
   input  logic              start_wb,
   input  logic              start_inv,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic [TAG_W-1:0]  start_tag,
   output logic              active,
   output logic              wb_mode,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_valid,
   input  logic              rd_dirty,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic [DATA_W-1:0] rd_data,
   output logic              clr_en,
   output logic              clr_valid,
   output logic              clr_dirty,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data
);

   logic             active_q, all_q, wb_q, inv_q;
   logic [IDX_W-1:0] idx_q;
   logic [TAG_W-1:0] tag_q;
   logic             hit, need_wb, step, last;

   assign hit     = rd_valid && (all_q || (rd_tag == tag_q));
   assign need_wb = active_q && hit && wb_q && rd_dirty;
   assign step    = active_q && (!need_wb || mem_wr_ready);
   assign last    = !all_q || (idx_q == IDX_W'(NUM_LINES - 1));

   assign active       = active_q;
   assign wb_mode      = wb_q;
   assign rd_idx       = idx_q;
   assign clr_en       = step && hit;
   assign clr_valid    = inv_q;
   assign clr_dirty    = wb_q;
   assign mem_wr_valid = need_wb;
   assign mem_wr_addr  = {rd_tag, idx_q, {OFF_W{1'b0}}};
   assign mem_wr_data  = rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         all_q    <= 1'b0;
         wb_q     <= 1'b0;
         inv_q    <= 1'b0;
         idx_q    <= '0;
         tag_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         all_q    <= start_all;
         wb_q     <= start_wb;
         inv_q    <= start_inv;
         idx_q    <= start_all ? '0 : start_idx;
         tag_q    <= start_tag;
      end else if (step) begin
         if (last) active_q <= 1'b0;
         else      idx_q    <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
   import dcache_maint_pkg::*;
#(
   parameter  int ADDR_W       = 32,
   parameter  int NUM_LINES    = 8,
   parameter  int LINE_LEN_FLD = 0,
   localparam int LINE_BYTES   = 16 << LINE_LEN_FLD,
   localparam int DATA_W       = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aux_wr_valid,
   output logic              aux_wr_ready,
   input  logic [2:0]        aux_wr_sel,
   input  logic [ADDR_W-1:0] aux_wr_data,
   output logic [ADDR_W-1:0] ctrl_rdata,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              fill_dirty,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data
);

   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int IDX_W = $clog2(NUM_LINES);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (LINE_LEN_FLD < 0 || LINE_LEN_FLD > 3) begin : g_bad_len
      $error("LINE_LEN_FLD must lie in 0..3");
   end
   if (ADDR_W <= CTRL_BUSY_BIT || TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too narrow for control word or tag");
   end

   aux_sel_e         sel;
   logic             dis_q, imode_q;
   logic             accept, is_inv, is_flush, start;
   logic             active, wb_mode;
   logic [IDX_W-1:0] rd_idx;
   logic             rd_valid, rd_dirty;
   logic [TAG_W-1:0] rd_tag;
   logic [DATA_W-1:0] rd_data;
   logic             clr_en, clr_valid, clr_dirty;
   logic             unused_bits;

   assign sel          = aux_sel_e'(aux_wr_sel);
   assign aux_wr_ready = !active;
   assign accept       = aux_wr_valid && aux_wr_ready;
   assign is_inv       = (sel == SEL_INV_ALL) || (sel == SEL_INV_LINE);
   assign is_flush     = (sel == SEL_FLUSH_ALL) || (sel == SEL_FLUSH_LINE);
   assign start        = accept && !dis_q && (is_inv || is_flush);
   assign unused_bits  = ^{aux_wr_data[OFF_W-1:0], fill_addr[OFF_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q   <= 1'b0;
         imode_q <= 1'b0;
      end else if (accept && sel == SEL_CTRL) begin
         dis_q   <= aux_wr_data[CTRL_DIS_BIT];
         imode_q <= aux_wr_data[CTRL_IMODE_BIT];
      end
   end

   always_comb begin
      ctrl_rdata                 = '0;
      ctrl_rdata[CTRL_DIS_BIT]   = dis_q;
      ctrl_rdata[CTRL_IMODE_BIT] = imode_q;
      ctrl_rdata[CTRL_BUSY_BIT]  = active && wb_mode;
   end

   dcache_maint_store #(
      .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_en   (fill_en && !active),
      .fill_idx  (fill_addr[OFF_W +: IDX_W]),
      .fill_tag  (fill_addr[ADDR_W-1 -: TAG_W]),
      .fill_data (fill_data),
      .fill_dirty(fill_dirty),
      .rd_idx    (rd_idx),
      .rd_valid  (rd_valid),
      .rd_dirty  (rd_dirty),
      .rd_tag    (rd_tag),
      .rd_data   (rd_data),
      .clr_en    (clr_en),
      .clr_valid (clr_valid),
      .clr_dirty (clr_dirty)
   );

   dcache_maint_walker #(
      .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W),
      .OFF_W(OFF_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) u_walker (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_all   ((sel == SEL_INV_ALL) || (sel == SEL_FLUSH_ALL)),
      .start_wb    (is_flush || (is_inv && imode_q)),
      .start_inv   (is_inv),
      .start_idx   (aux_wr_data[OFF_W +: IDX_W]),
      .start_tag   (aux_wr_data[ADDR_W-1 -: TAG_W]),
      .active      (active),
      .wb_mode     (wb_mode),
      .rd_idx      (rd_idx),
      .rd_valid    (rd_valid),
      .rd_dirty    (rd_dirty),
      .rd_tag      (rd_tag),
      .rd_data     (rd_data),
      .clr_en      (clr_en),
      .clr_valid   (clr_valid),
      .clr_dirty   (clr_dirty),
      .mem_wr_valid(mem_wr_valid),
      .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr (mem_wr_addr),
      .mem_wr_data (mem_wr_data)
   );

endmodule

// File: rtl/dcache_maint_chk.sv
module dcache_maint_chk
   import dcache_maint_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4,
   parameter int DATA_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              aux_wr_valid,
   input logic              aux_wr_ready,
   input logic [2:0]        aux_wr_sel,
   input logic [ADDR_W-1:0] ctrl_rdata,
   input logic              mem_wr_valid,
   input logic              mem_wr_ready,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [DATA_W-1:0] mem_wr_data
);

   logic [ADDR_W-1:0] ctrl_mask;
   logic              cmd_sel;

   always_comb begin
      ctrl_mask                 = '1;
      ctrl_mask[CTRL_DIS_BIT]   = 1'b0;
      ctrl_mask[CTRL_IMODE_BIT] = 1'b0;
      ctrl_mask[CTRL_BUSY_BIT]  = 1'b0;
   end

   assign cmd_sel = (aux_wr_sel >= 3'd1) && (aux_wr_sel <= 3'd4);

   assert_ctrl_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata & ctrl_mask) == '0);

   assert_busy_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rdata[CTRL_BUSY_BIT] |-> !aux_wr_ready);

   assert_wb_stalls_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> !aux_wr_ready);

   assert_disabled_no_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_wr_valid && aux_wr_ready && ctrl_rdata[CTRL_DIS_BIT] && cmd_sel) |=> aux_wr_ready);

   assert_wb_aligned_R13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (mem_wr_addr[OFF_W-1:0] == '0));

   assert_wb_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

endmodule

bind dcache_maint dcache_maint_chk #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .aux_wr_valid(aux_wr_valid),
   .aux_wr_ready(aux_wr_ready),
   .aux_wr_sel  (aux_wr_sel),
   .ctrl_rdata  (ctrl_rdata),
   .mem_wr_valid(mem_wr_valid),
   .mem_wr_ready(mem_wr_ready),
   .mem_wr_addr (mem_wr_addr),
   .mem_wr_data (mem_wr_data)
);

// File: tb/dcache_maint_bench.sv
module dcache_maint_bench;
   import dcache_maint_pkg::*;

   localparam int ADDR_W = 32;
   localparam int DATA_W = 128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              aux_wr_valid = 1'b0;
   logic              aux_wr_ready;
   logic [2:0]        aux_wr_sel = 3'd0;
   logic [ADDR_W-1:0] aux_wr_data = '0;
   logic [ADDR_W-1:0] ctrl_rdata;
   logic              fill_en = 1'b0;
   logic [ADDR_W-1:0] fill_addr = '0;
   logic [DATA_W-1:0] fill_data = '0;
   logic              fill_dirty = 1'b0;
   logic              mem_wr_valid;
   logic              mem_wr_ready = 1'b1;
   logic [ADDR_W-1:0] mem_wr_addr;
   logic [DATA_W-1:0] mem_wr_data;

   always #4 clk = ~clk;

   dcache_maint u_dcache_maint (
      .clk(clk), .rst_n(rst_n),
      .aux_wr_valid(aux_wr_valid), .aux_wr_ready(aux_wr_ready),
      .aux_wr_sel(aux_wr_sel), .aux_wr_data(aux_wr_data), .ctrl_rdata(ctrl_rdata),
      .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data), .fill_dirty(fill_dirty),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int wr_seen = 0;
   int bp_cnt  = 0;
   bit bp_on   = 1'b0;
   bit done    = 1'b0;
   string cur_req = "R3";
   logic [ADDR_W-1:0] exp_addr_q [$];
   logic [DATA_W-1:0] exp_data_q [$];

   function automatic logic [ADDR_W-1:0] line_addr(int tag, int idx);
      return {tag[24:0], idx[2:0], 4'h0};
   endfunction

   function automatic logic [DATA_W-1:0] line_data(int tag, int idx);
      logic [31:0] w;
      w = {tag[23:0], idx[3:0], 4'h5};
      return {w ^ 32'h1111_0000, w ^ 32'h0F0F_0000, w ^ 32'h00FF_0000, w};
   endfunction

   task automatic check(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic expect_wb(int tag, int idx);
      exp_addr_q.push_back(line_addr(tag, idx));
      exp_data_q.push_back(line_data(tag, idx));
   endtask

   task automatic fill(int tag, int idx, bit dirty);
      @(negedge clk);
      fill_en = 1'b1;
      fill_addr = line_addr(tag, idx);
      fill_data = line_data(tag, idx);
      fill_dirty = dirty;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic aux_write(logic [2:0] sel, logic [ADDR_W-1:0] data, output int waits);
      waits = 0;
      @(negedge clk);
      aux_wr_valid = 1'b1;
      aux_wr_sel = sel;
      aux_wr_data = data;
      while (!aux_wr_ready) begin
         waits++;
         @(negedge clk);
      end
      @(negedge clk);
      aux_wr_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!aux_wr_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_drained(string req);
      check(exp_addr_q.size() == 0, req, exp_addr_q.size(), 0);
   endtask

   // memory backpressure
   always @(posedge clk) begin
      #2;
      bp_cnt++;
      mem_wr_ready = bp_on ? (bp_cnt % 3 != 0) : 1'b1;
   end

   // scoreboard monitor
   bit                held = 1'b0;
   logic [ADDR_W-1:0] held_addr;
   always @(negedge clk) begin
      if (rst_n) begin
         if (held) begin
            check(mem_wr_valid && mem_wr_addr == held_addr, "R14", mem_wr_addr, held_addr);
         end
         held = mem_wr_valid && !mem_wr_ready;
         held_addr = mem_wr_addr;
         if (mem_wr_valid && mem_wr_ready) begin
            wr_seen++;
            check(mem_wr_addr[3:0] == 4'h0, "R13", mem_wr_addr, 0);
            if (exp_addr_q.size() == 0) begin
               check(1'b0, {cur_req, " unexpected write"}, mem_wr_addr, 0);
            end else begin
               logic [ADDR_W-1:0] ea;
               logic [DATA_W-1:0] ed;
               ea = exp_addr_q.pop_front();
               ed = exp_data_q.pop_front();
               check(mem_wr_addr == ea, cur_req, mem_wr_addr, ea);
               check(mem_wr_data == ed, cur_req, mem_wr_data, ed);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int w;
      int seen0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(aux_wr_ready == 1'b1, "R1", aux_wr_ready, 1);
      check(ctrl_rdata == '0, "R1", ctrl_rdata, 0);
      check(mem_wr_valid == 1'b0, "R1", mem_wr_valid, 0);
      rst_n = 1'b1;

      // R2 control bits
      aux_write(SEL_CTRL, 32'hFFFF_FFFF, w);
      check(ctrl_rdata == 32'h41, "R2", ctrl_rdata, 32'h41);
      aux_write(SEL_CTRL, 32'h0, w);
      check(ctrl_rdata == 32'h0, "R2", ctrl_rdata, 0);

      // R3 / R12 / R6 flush all with mixed lines under backpressure
      bp_on = 1'b1;
      for (int i = 0; i < 8; i++) fill(100 + i, i, (i % 2) == 0);
      cur_req = "R3";
      for (int i = 0; i < 8; i += 2) expect_wb(100 + i, i);
      seen0 = wr_seen;
      aux_write(SEL_FLUSH_ALL, 0, w);
      check(ctrl_rdata[8] == 1'b1, "R6", ctrl_rdata[8], 1);
      wait_idle();
      check(ctrl_rdata[8] == 1'b0, "R6", ctrl_rdata[8], 0);
      check_drained("R3");
      check(wr_seen - seen0 == 4, "R12", wr_seen - seen0, 4);
      seen0 = wr_seen;
      aux_write(SEL_FLUSH_ALL, 0, w);
      wait_idle();
      check(wr_seen == seen0, "R3", wr_seen - seen0, 0);

      // R7 stall of a control write during a walk
      fill(200, 1, 1'b1);
      cur_req = "R7";
      expect_wb(200, 1);
      aux_write(SEL_FLUSH_ALL, 0, w);
      aux_write(SEL_CTRL, 32'h40, w);
      check(w > 0, "R7", w, 1);
      check_drained("R7");
      check(ctrl_rdata == 32'h40, "R7", ctrl_rdata, 32'h40);

      // R5 write-back invalidate
      fill(300, 2, 1'b1);
      fill(301, 5, 1'b1);
      fill(302, 6, 1'b0);
      cur_req = "R5";
      expect_wb(300, 2);
      expect_wb(301, 5);
      aux_write(SEL_INV_ALL, 0, w);
      check(ctrl_rdata[8] == 1'b1, "R6", ctrl_rdata[8], 1);
      wait_idle();
      check_drained("R5");
      seen0 = wr_seen;
      aux_write(SEL_FLUSH_ALL, 0, w);
      wait_idle();
      check(wr_seen == seen0, "R5", wr_seen - seen0, 0);

      // R4 discard invalidate
      aux_write(SEL_CTRL, 32'h0, w);
      for (int i = 0; i < 4; i++) fill(400 + i, i, 1'b1);
      cur_req = "R4";
      seen0 = wr_seen;
      aux_write(SEL_INV_ALL, 0, w);
      check(!aux_wr_ready && ctrl_rdata[8] == 1'b0, "R6", ctrl_rdata[8], 0);
      wait_idle();
      aux_write(SEL_FLUSH_ALL, 0, w);
      wait_idle();
      check(wr_seen == seen0, "R4", wr_seen - seen0, 0);

      // R8 / R10 / R13 per-line flush with offset address
      fill(500, 3, 1'b1);
      fill(501, 4, 1'b1);
      cur_req = "R8";
      expect_wb(500, 3);
      aux_write(SEL_FLUSH_LINE, line_addr(500, 3) | 32'hB, w);
      wait_idle();
      check_drained("R8");
      cur_req = "R10";
      expect_wb(501, 4);
      aux_write(SEL_FLUSH_ALL, 0, w);
      wait_idle();
      check_drained("R10");

      // R9 per-line miss
      fill(600, 5, 1'b1);
      cur_req = "R9";
      seen0 = wr_seen;
      aux_write(SEL_FLUSH_LINE, line_addr(601, 5), w);
      wait_idle();
      aux_write(SEL_CTRL, 32'h40, w);
      aux_write(SEL_INV_LINE, line_addr(601, 5) | 32'h7, w);
      wait_idle();
      check(wr_seen == seen0, "R9", wr_seen - seen0, 0);
      expect_wb(600, 5);
      aux_write(SEL_FLUSH_ALL, 0, w);
      wait_idle();
      check_drained("R9");

      // R4 per-line discard
      aux_write(SEL_CTRL, 32'h0, w);
      fill(700, 6, 1'b1);
      fill(701, 7, 1'b1);
      cur_req = "R4";
      aux_write(SEL_INV_LINE, line_addr(700, 6) | 32'h1, w);
      wait_idle();
      expect_wb(701, 7);
      aux_write(SEL_FLUSH_ALL, 0, w);
      wait_idle();
      check_drained("R4");

      // R11 disabled cache ignores commands
      bp_on = 1'b0;
      aux_write(SEL_CTRL, 32'h1, w);
      fill(800, 0, 1'b1);
      cur_req = "R11";
      seen0 = wr_seen;
      aux_write(SEL_INV_ALL, 0, w);
      check(aux_wr_ready == 1'b1, "R11", aux_wr_ready, 1);
      aux_write(SEL_FLUSH_ALL, 0, w);
      check(aux_wr_ready == 1'b1, "R11", aux_wr_ready, 1);
      repeat (4) @(negedge clk);
      check(wr_seen == seen0, "R11", wr_seen - seen0, 0);
      aux_write(SEL_CTRL, 32'h0, w);
      expect_wb(800, 0);
      aux_write(SEL_FLUSH_ALL, 0, w);
      wait_idle();
      check_drained("R11");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule